// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the order in which the columns of an open SDRAM row are visited during one burst. A requester hands it a start column, a 3-bit length code and an ordering choice. The block then emits one column address per accepted beat, and a flag on the final beat. A memory model or a memory controller uses it as the column stepper behind its read and write paths. It does not decode commands and it stores no data.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. Inside that block they follow either a wrapping increment or an XOR pattern. A full-page burst always uses the increment pattern. It walks all `2**COL_W` columns of the row, returns to column 0 after the top column, and continues until a stop request arrives. Any beat can be ended early with the stop input.

Both edges of the block are valid/ready streams. On the request side, `start_ready` is high only while no burst is in progress, so a new request waits until the current burst has finished. On the column side, the consumer holds the burst by keeping `col_ready` low. While it does so, the offered beat stays unchanged and no beat is skipped. `burst_stop` is a plain control pin.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset, `col_valid` is 0 and `start_ready` is 1.
- R2: A request is accepted in a cycle in which `start_valid` and `start_ready` are both high. `start_ready` stays low for as long as a burst is active. The first beat is offered in the cycle after acceptance, and its address equals the accepted `start_col`.
- R3: Length code 000 gives 1 beat, 001 gives 2 beats, 010 gives 4, 011 gives 8 and 111 gives a full page. Codes 100, 101 and 110 act as a length of 1.
- R4: With `interleave`=0 and a fixed length N, beat k has address `(start & ~(N-1)) | ((start + k) mod N)`. In other words, the low log2(N) bits count up and wrap, and the upper bits stay fixed.
- R5: With `interleave`=1 and a fixed length N, beat k has address `start XOR k`, where k never exceeds N-1.
- R6: A full-page burst ignores `interleave`. Its beats count up by one modulo `2**COL_W`, and `col_last` is never raised during it.
- R7: In a fixed-length burst, `col_last` is high exactly on beat N-1. When that beat is accepted, `col_valid` is low in the next cycle and `start_ready` is high again.
- R8: While `col_valid` is high and `col_ready` is low (with no stop request), the next cycle still has `col_valid` high, with `col_addr` and `col_last` unchanged.
- R9: If `burst_stop` is high in a cycle in which `col_valid` is high, the beat offered in that cycle is still transferred if `col_ready` is high. `col_valid` is then low from the next cycle on. `burst_stop` has no effect while no burst is active, and this includes the cycle in which a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | A burst request is present |
| start_ready | output | 1 | The block can accept a request (no burst active) |
| start_col | input | COL_W | Start column of the request |
| len_code | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects wrapping increment |
| col_valid | output | 1 | A column beat is offered |
| col_ready | input | 1 | The consumer takes the offered beat |
| col_addr | output | COL_W | Column address of the offered beat |
| col_last | output | 1 | The offered beat is the final beat of a fixed-length burst |
| burst_stop | input | 1 | Ends the active burst after the current cycle |

## Verification
The bench builds the block with `COL_W`=5, so a row holds 32 columns. A full-page burst therefore wraps from 31 back to 0 after a few dozen cycles, and the wrap is crossed many times in one run, including under back-pressure. The three fixed lengths above 1 still fit inside that row, so every aligned-block case, every length code (including the unused ones) and both orderings are reached at a start column in every block position. Randomly mixed ready stalls, stop requests at any beat and stops while idle exercise the points where the handshake rules and the early-stop rules interact.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  // Decoded shape of one burst request.
  typedef struct packed {
    logic       full_page;   // run through the whole row until stopped
    logic [1:0] log2_len;    // log2 of the fixed length (0..3)
    logic       interleave;  // XOR ordering (never set for full page)
  } burst_shape_t;

  localparam logic [2:0] LEN_CODE_1    = 3'b000;
  localparam logic [2:0] LEN_CODE_2    = 3'b001;
  localparam logic [2:0] LEN_CODE_4    = 3'b010;
  localparam logic [2:0] LEN_CODE_8    = 3'b011;
  localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

endpackage

// File: rtl/colseq_len_dec.sv
module colseq_len_dec
  import colseq_pkg::*;
(
  input  logic [2:0]   len_code,
  input  logic         interleave,
  output burst_shape_t shape
);

  always_comb begin
    shape = '0;
    unique case (len_code)
      LEN_CODE_2:    shape.log2_len = 2'd1;
      LEN_CODE_4:    shape.log2_len = 2'd2;
      LEN_CODE_8:    shape.log2_len = 2'd3;
      LEN_CODE_PAGE: shape.full_page = 1'b1;
      default:       shape.log2_len = 2'd0;  // 000 and unused codes: single beat
    endcase
    // A full page always steps by increment.
    shape.interleave = interleave & ~shape.full_page;
  end

endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fire,
  input  burst_shape_t     shape_in,
  input  logic             out_fire,
  input  logic             stop,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask,
  output logic             last,
  output logic             full_page,
  output logic             interleave
);

  localparam logic [COL_W-1:0] ONE      = COL_W'(1);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  burst_shape_t shape_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      beat    <= '0;
      shape_q <= '0;
    end else if (start_fire) begin
      active  <= 1'b1;
      beat    <= '0;
      shape_q <= shape_in;
    end else if (active) begin
      if (stop || (out_fire && last)) begin
        active <= 1'b0;
      end else if (out_fire) begin
        beat <= beat + ONE;
      end
    end
  end

  always_comb begin
    if (shape_q.full_page) begin
      mask = ALL_ONES;
    end else begin
      mask = (ONE << shape_q.log2_len) - ONE;
    end
  end

  assign last       = active & ~shape_q.full_page & (beat == mask);
  assign full_page  = shape_q.full_page;
  assign interleave = shape_q.interleave;

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && out_fire && last && !start_fire) |=> !active);

endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] low_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (load) begin
      start_q <= start_col;
    end
  end

  // The carry out of the masked field never reaches the output, so the field wraps.
  assign seq_sum = start_q + beat;
  assign low_src = interleave ? (start_q ^ beat) : seq_sum;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = mask[i] ? low_src[i] : start_q[i];
  end

endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  input  logic             burst_stop
);

  burst_shape_t     shape_d;
  logic             active;
  logic             start_fire;
  logic             out_fire;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] mask;
  logic             page_q;
  logic             il_q;

  assign start_ready = ~active;
  assign start_fire  = start_valid & ~active;
  assign out_fire    = active & col_ready;

  colseq_len_dec u_dec (
    .len_code   (len_code),
    .interleave (interleave),
    .shape      (shape_d)
  );

  colseq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_fire (start_fire),
    .shape_in   (shape_d),
    .out_fire   (out_fire),
    .stop       (burst_stop),
    .active     (active),
    .beat       (beat),
    .mask       (mask),
    .last       (col_last),
    .full_page  (page_q),
    .interleave (il_q)
  );

  colseq_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_fire),
    .start_col  (start_col),
    .beat       (beat),
    .mask       (mask),
    .interleave (il_q),
    .col        (col_addr)
  );

  assign col_valid = active;

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (col_valid && col_addr == $past(start_col)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !burst_stop) |=>
      (col_valid && $stable(col_addr) && $stable(col_last)));

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && burst_stop) |=> (!col_valid && start_ready));

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && page_q && !burst_stop) |=>
      (col_valid && !col_last && col_addr == COL_W'($past(col_addr) + COL_W'(1))));

endmodule

// File: tb/tb_sdram_burst_colseq.sv
module tb_sdram_burst_colseq;

  localparam int CW   = 5;
  localparam int PAGE = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [CW-1:0] start_col = '0;
  logic [2:0]    len_code = '0;
  logic          interleave = 1'b0;
  logic          col_valid;
  logic          col_ready = 1'b0;
  logic [CW-1:0] col_addr;
  logic          col_last;
  logic          burst_stop = 1'b0;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sdram_burst_colseq #(.COL_W(CW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .start_col   (start_col),
    .len_code    (len_code),
    .interleave  (interleave),
    .col_valid   (col_valid),
    .col_ready   (col_ready),
    .col_addr    (col_addr),
    .col_last    (col_last),
    .burst_stop  (burst_stop)
  );

  // Behavioural reference state
  bit m_active = 0;
  bit m_full   = 0;
  bit m_il     = 0;
  int m_start  = 0;
  int m_n      = 1;
  int m_k      = 0;
  bit m_stalled = 0;

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 1;
    endcase
  endfunction

  function automatic bit exp_last();
    return m_active && !m_full && (m_k == m_n - 1);
  endfunction

  function automatic int exp_col();
    int base, off;
    if (m_full) return (m_start + m_k) % PAGE;
    base = m_start - (m_start % m_n);
    if (m_il) off = (m_start % m_n) ^ m_k;
    else      off = ((m_start % m_n) + m_k) % m_n;
    return base + off;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_k = 0; m_stalled = 0;
    end else if (!m_active) begin
      m_stalled = 0;
      if (start_valid) begin
        m_active = 1;
        m_start  = int'(start_col);
        m_full   = (len_code == 3'b111);
        m_n      = m_full ? PAGE : len_of(len_code);
        m_il     = interleave && !m_full;
        m_k      = 0;
      end
    end else begin
      m_stalled = !col_ready && !burst_stop;
      if (burst_stop || (col_ready && exp_last())) m_active = 0;
      else if (col_ready) m_k = m_k + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string atag;
    check("R2/R7/R9 col_valid", int'(col_valid), int'(m_active));
    check("R2/R7 start_ready", int'(start_ready), int'(!m_active));
    if (m_active) begin
      if (m_full)    atag = "R6 page col_addr";
      else if (m_il) atag = "R3/R5 col_addr";
      else           atag = "R3/R4 col_addr";
      if (m_stalled) atag = {atag, " R8"};
      check(atag, int'(col_addr), exp_col());
      check(m_full ? "R6 col_last" : "R3/R7 col_last", int'(col_last), int'(exp_last()));
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic burst(input logic [2:0] code, input bit il, input int col, input int stop_at);
    int cnt = 0;
    step();
    start_valid = 1'b1; len_code = code; interleave = il; start_col = CW'(col);
    col_ready = 1'b1;
    step();
    start_valid = 1'b0;
    while (m_active && cnt < 100) begin
      burst_stop = (cnt == stop_at);
      step();
      burst_stop = 1'b0;
      cnt++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, also held while reset is asserted
    check("R1 col_valid", int'(col_valid), 0);
    check("R1 start_ready", int'(start_ready), 1);
    rst_n = 1'b1;
    step();
    check("R1 col_valid after release", int'(col_valid), 0);

    // Directed: every code, both orderings, several start positions
    for (int c = 0; c < 8; c++) begin
      for (int il = 0; il < 2; il++) begin
        for (int s = 0; s < 4; s++) begin
          burst(3'(c), il[0], (s * 11 + 3) % PAGE, (c == 7) ? 40 + s : 200);
        end
      end
    end
    // R9: stop on the very first beat of an 8-beat burst
    burst(3'b011, 1'b0, 13, 0);
    // R9: stop raised while idle, including in the request cycle
    step();
    burst_stop = 1'b1;
    step();
    start_valid = 1'b1; len_code = 3'b010; interleave = 1'b1; start_col = CW'(6);
    step();
    start_valid = 1'b0; burst_stop = 1'b0;
    repeat (6) step();

    // Random mix with back-pressure and stops
    for (int i = 0; i < 4000; i++) begin
      step();
      start_valid = ($urandom % 3) == 0;
      start_col   = CW'($urandom);
      len_code    = 3'($urandom);
      interleave  = 1'($urandom);
      col_ready   = ($urandom % 4) != 0;
      burst_stop  = ($urandom % 40) == 0;
    end
    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule